// File: doc/BRIEF.md
# ACPI Sleep State Power Sequencer

This block is a standby-domain controller clocked from an always-on 32 kHz clock. It holds the system in the working state (S0) and moves it into one of the sleep states S1, S3, S4 or S5 only when software writes a sleep-type code through a small register write port. The block never chooses to sleep by itself. A wake event brings the system back to the working state. From S1 the return is immediate. From the deeper states the rails are brought back up in a timed order.

The working power is split across two enables. One rail feeds system memory. The other, auxiliary, rail feeds the rest of the working domain. The other outputs are a set of clock-gate enables, two generic device-sleep controls, a PCI/IDE I/O isolation signal, and a memory self-refresh request with its acknowledge. Save-to-RAM (S3) puts memory into self-refresh and keeps only the memory rail powered. A configuration input selects the state after reset: either both rails powered at once (for systems that never use sleep states), or soft-off waiting for a wake event.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, if `cfg_joint_pwrup` is 1 the block is in S0, with both rails on, all clock enables high, `dev_sleep`=00, `io_isolate`=0 and `state_code`=0. If it is 0 the block is in S5, with both rails off, all clock enables low and `state_code`=5.
- R2: A write to address 0 while in S0 takes `wr_data[2:0]` as the sleep type: 1 selects S1, 3 selects S3, 4 selects S4 and 5 selects S5. Codes 0, 2, 6 and 7 leave the state unchanged. A write to address 0 in any state other than S0 has no effect.
- R3: In S1 both rails stay on, `clk_gate_en` equals the keep-on mask, `dev_sleep`=11, `io_isolate`=1 and `state_code`=1.
- R4: A wake event in S1 returns the block to S0 at the next clock edge: all clock enables go high, `dev_sleep`=00 and `io_isolate`=0.
- R5: A request for S3 raises `sr_req` and gates all clocks while keeping both rails on. `state_code` reads 3. The auxiliary rail drops only on the edge that samples `sr_ack`=1, and the memory rail stays on.
- R6: In S4 and S5 both rails are off, all clock enables are low, and `state_code` reads 4 or 5.
- R7: A wake event in S3, S4 or S5 turns on the memory rail at once. The auxiliary rail follows step+1 cycles later, and the clocks follow step+1 cycles after that, where step is the step-delay register. `sr_req` falls when the clocks turn on, and `state_code` reads 0 during these steps.
- R8: `wake_sts` is set by every accepted wake and stays set until a write to address 1 with bit 0 = 1. Writing 0 there has no effect. A wake on the same edge as a clear wins.
- R9: A wake event in S0, or while S3 entry is waiting for `sr_ack`, changes neither the state nor `wake_sts`.
- R10: Address 2 holds the keep-on clock mask (`wr_data[NCLK-1:0]`, reset 0). Address 3 holds the step delay (`wr_data[DLY_W-1:0]`, reset `DLY_RST`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_32k | input | 1 | Always-on 32 kHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_joint_pwrup | input | 1 | 1: reset into S0 with both rails on; 0: reset into S5 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 sleep type, 1 wake clear, 2 keep mask, 3 step) |
| wr_data | input | DATA_W | Write data |
| wake_evt | input | 1 | Synchronised wake event |
| sr_ack | input | 1 | Memory self-refresh acknowledge |
| mem_rail_en | output | 1 | Memory rail enable |
| aux_rail_en | output | 1 | Auxiliary working-domain rail enable |
| clk_gate_en | output | NCLK | Per-clock enables |
| dev_sleep | output | 2 | Generic device-sleep controls |
| io_isolate | output | 1 | PCI/IDE I/O isolation |
| sr_req | output | 1 | Memory self-refresh request |
| state_code | output | 3 | Current power state code |
| wake_sts | output | 1 | Sticky wake status |

## Verification
A wrong internal state appears at the ports on the same cycle it is entered, because every output is decoded directly from the state register. A stray transition out of S0 therefore shows at once as a dropped clock enable or a changed `state_code`. A wrong step count appears as a rail or clock edge that lands one or more cycles early or late against step+1. That is measured by counting cycles between the rail and clock edges after each wake. A missed self-refresh handshake appears as the auxiliary rail dropping before `sr_ack` is seen, or as the block staying in S3 entry after it.

// File: rtl/pwr_seq_pkg.sv
// Shared types and constants for the sleep-state power sequencer.
// Assumes that sleep-type codes fit in 3 bits and that register addresses fit in 2 bits.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_S0       = 3'd0,
        ST_S1       = 3'd1,
        ST_S3_ENTRY = 3'd2,
        ST_S3       = 3'd3,
        ST_S4       = 3'd4,
        ST_S5       = 3'd5,
        ST_UP_MEM   = 3'd6,
        ST_UP_AUX   = 3'd7
    } pwr_state_e;

    localparam logic [2:0] CODE_S0 = 3'd0;
    localparam logic [2:0] CODE_S1 = 3'd1;
    localparam logic [2:0] CODE_S3 = 3'd3;
    localparam logic [2:0] CODE_S4 = 3'd4;
    localparam logic [2:0] CODE_S5 = 3'd5;

    localparam logic [1:0] ADDR_SLEEP   = 2'd0;
    localparam logic [1:0] ADDR_WAKECLR = 2'd1;
    localparam logic [1:0] ADDR_KEEP    = 2'd2;
    localparam logic [1:0] ADDR_STEP    = 2'd3;

endpackage

// File: rtl/pwr_seq_regs.sv
// Register write port for the sequencer.
// Decodes sleep requests, holds the keep-on clock mask and the step delay,
// and keeps the sticky wake-status bit.
// Assumes that NCLK <= DATA_W, that DLY_W <= DATA_W and that DATA_W >= 3.
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NCLK    = 4,
    parameter int DLY_W   = 8,
    parameter int DLY_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_set,
    output logic              slp_req,
    output logic [2:0]        slp_code,
    output logic [NCLK-1:0]   keep_mask,
    output logic [DLY_W-1:0]  step_dly,
    output logic              wake_sts
);

    localparam logic [DLY_W-1:0] STEP_INIT = DLY_W'(DLY_RST);

    logic wake_clr;

    // Decode the write strobes for the sleep request and the wake clear.
    always_comb begin
        slp_req  = wr_en && (wr_addr == ADDR_SLEEP);
        slp_code = wr_data[2:0];
        wake_clr = wr_en && (wr_addr == ADDR_WAKECLR) && wr_data[0];
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_mask <= '0;
            step_dly  <= STEP_INIT;
        end else if (wr_en) begin
            if (wr_addr == ADDR_KEEP) keep_mask <= wr_data[NCLK-1:0];
            if (wr_addr == ADDR_STEP) step_dly  <= wr_data[DLY_W-1:0];
        end
    end

    // Sticky wake status: set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_sts <= 1'b0;
        else if (wake_set) wake_sts <= 1'b1;
        else if (wake_clr) wake_sts <= 1'b0;
    end

endmodule

// File: rtl/pwr_seq_timer.sv
// Step-delay down-counter shared by the power-up steps.
// A load pulse sets the count. done is high once the count reaches zero.
// Assumes that load is pulsed on the edge that enters each timed step.
module pwr_seq_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             done
);

    logic [DLY_W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Report expiry.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Power-state machine.
// Leaves S0 only on a software sleep request. Returns on wake events.
// Waits for the self-refresh acknowledge on S3 entry and walks the two
// timed power-up steps on the way back from S3, S4 and S5.
// Assumes that wake_evt and sr_ack are already synchronous to clk.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       joint_pwrup,
    input  logic       slp_req,
    input  logic [2:0] slp_code,
    input  logic       wake_evt,
    input  logic       sr_ack,
    input  logic       tmr_done,
    output pwr_state_e state,
    output logic       tmr_load,
    output logic       wake_take
);

    pwr_state_e nxt;

    // Next-state selection, timer load and wake acceptance.
    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        wake_take = 1'b0;
        unique case (state)
            ST_S0: begin
                if (slp_req) begin
                    case (slp_code)
                        CODE_S1: nxt = ST_S1;
                        CODE_S3: nxt = ST_S3_ENTRY;
                        CODE_S4: nxt = ST_S4;
                        CODE_S5: nxt = ST_S5;
                        default: nxt = ST_S0;
                    endcase
                end
            end
            ST_S1: begin
                if (wake_evt) begin
                    nxt       = ST_S0;
                    wake_take = 1'b1;
                end
            end
            ST_S3_ENTRY: begin
                if (sr_ack) nxt = ST_S3;
            end
            ST_S3, ST_S4, ST_S5: begin
                if (wake_evt) begin
                    nxt       = ST_UP_MEM;
                    tmr_load  = 1'b1;
                    wake_take = 1'b1;
                end
            end
            ST_UP_MEM: begin
                if (tmr_done) begin
                    nxt      = ST_UP_AUX;
                    tmr_load = 1'b1;
                end
            end
            ST_UP_AUX: begin
                if (tmr_done) nxt = ST_S0;
            end
            default: nxt = ST_S0;
        endcase
    end

    // State register. The reset target follows the joint power-up option.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= joint_pwrup ? ST_S0 : ST_S5;
        else        state <= nxt;
    end

endmodule

// File: rtl/pwr_seq_decode.sv
// Output decode from the power state.
// Produces the rail enables, clock enables, device-sleep controls, isolation,
// self-refresh request and the reported state code.
// Assumes that the outputs may be decoded directly from the state flops.
module pwr_seq_decode
    import pwr_seq_pkg::*;
#(
    parameter int NCLK = 4
) (
    input  pwr_state_e      state,
    input  logic [NCLK-1:0] keep_mask,
    output logic            mem_en,
    output logic            aux_en,
    output logic [NCLK-1:0] clk_en,
    output logic [1:0]      dev_sleep,
    output logic            io_iso,
    output logic            sr_req,
    output logic [2:0]      code
);

    logic asleep;

    // Sleep controls are active in every state except S0.
    always_comb asleep = (state != ST_S0);

    // Rails, clocks and reported code for each state.
    always_comb begin
        mem_en = 1'b0;
        aux_en = 1'b0;
        clk_en = '0;
        sr_req = 1'b0;
        code   = CODE_S0;
        unique case (state)
            ST_S0: begin
                mem_en = 1'b1;
                aux_en = 1'b1;
                clk_en = '1;
            end
            ST_S1: begin
                mem_en = 1'b1;
                aux_en = 1'b1;
                clk_en = keep_mask;
                code   = CODE_S1;
            end
            ST_S3_ENTRY: begin
                mem_en = 1'b1;
                aux_en = 1'b1;
                sr_req = 1'b1;
                code   = CODE_S3;
            end
            ST_S3: begin
                mem_en = 1'b1;
                sr_req = 1'b1;
                code   = CODE_S3;
            end
            ST_S4: code = CODE_S4;
            ST_S5: code = CODE_S5;
            ST_UP_MEM: begin
                mem_en = 1'b1;
                sr_req = 1'b1;
            end
            ST_UP_AUX: begin
                mem_en = 1'b1;
                aux_en = 1'b1;
                sr_req = 1'b1;
            end
            default: code = CODE_S0;
        endcase
    end

    // Device-sleep pair and I/O isolation.
    always_comb begin
        dev_sleep = {2{asleep}};
        io_iso    = asleep;
    end

endmodule

// File: rtl/pwr_seq_top.sv
// Top level of the ACPI sleep-state power sequencer.
// Connects the register port, the state machine, the step timer and the output decode.
// Assumes a free-running 32 kHz clock and inputs already synchronous to it.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NCLK    = 4,
    parameter int DLY_W   = 8,
    parameter int DLY_RST = 4
) (
    input  logic              clk_32k,
    input  logic              rst_n,
    input  logic              cfg_joint_pwrup,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_evt,
    input  logic              sr_ack,
    output logic              mem_rail_en,
    output logic              aux_rail_en,
    output logic [NCLK-1:0]   clk_gate_en,
    output logic [1:0]        dev_sleep,
    output logic              io_isolate,
    output logic              sr_req,
    output logic [2:0]        state_code,
    output logic              wake_sts
);

    logic             slp_req;
    logic [2:0]       slp_code;
    logic [NCLK-1:0]  keep_mask;
    logic [DLY_W-1:0] step_dly;
    logic             tmr_load;
    logic             tmr_done;
    logic             wake_take;
    pwr_state_e       state;

    pwr_seq_regs #(
        .DATA_W (DATA_W),
        .NCLK   (NCLK),
        .DLY_W  (DLY_W),
        .DLY_RST(DLY_RST)
    ) u_regs (
        .clk      (clk_32k),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wake_set (wake_take),
        .slp_req  (slp_req),
        .slp_code (slp_code),
        .keep_mask(keep_mask),
        .step_dly (step_dly),
        .wake_sts (wake_sts)
    );

    pwr_seq_fsm u_fsm (
        .clk        (clk_32k),
        .rst_n      (rst_n),
        .joint_pwrup(cfg_joint_pwrup),
        .slp_req    (slp_req),
        .slp_code   (slp_code),
        .wake_evt   (wake_evt),
        .sr_ack     (sr_ack),
        .tmr_done   (tmr_done),
        .state      (state),
        .tmr_load   (tmr_load),
        .wake_take  (wake_take)
    );

    pwr_seq_timer #(
        .DLY_W(DLY_W)
    ) u_tmr (
        .clk     (clk_32k),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(step_dly),
        .done    (tmr_done)
    );

    pwr_seq_decode #(
        .NCLK(NCLK)
    ) u_dec (
        .state    (state),
        .keep_mask(keep_mask),
        .mem_en   (mem_rail_en),
        .aux_en   (aux_rail_en),
        .clk_en   (clk_gate_en),
        .dev_sleep(dev_sleep),
        .io_iso   (io_isolate),
        .sr_req   (sr_req),
        .code     (state_code)
    );

endmodule

// File: rtl/pwr_seq_chk.sv
// Port-level checker for pwr_seq_top, attached by bind.
// Relates the rails, clocks, sleep controls and status across cycles.
module pwr_seq_chk #(
    parameter int DATA_W = 8,
    parameter int NCLK   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              mem_rail_en,
    input logic              aux_rail_en,
    input logic [NCLK-1:0]   clk_gate_en,
    input logic [1:0]        dev_sleep,
    input logic              io_isolate,
    input logic              sr_req,
    input logic [2:0]        state_code,
    input logic              wake_sts
);

    logic in_s0;
    always_comb in_s0 = (state_code == 3'd0) && (&clk_gate_en);

    // R2: S0 is left only after a write to the sleep-type address
    p_stay_s0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_s0 && !(wr_en && wr_addr == 2'd0)) |=> in_s0);

    // R3: S1 keeps both rails and asserts the sleep controls
    p_s1_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1) |-> (mem_rail_en && aux_rail_en && io_isolate && dev_sleep == 2'b11));

    // R5: aux rail is never powered without memory
    p_aux_needs_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rail_en |-> mem_rail_en);

    // R5: S3 reported only with self-refresh requested
    p_s3_selfrefresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |-> sr_req);

    // R6: clocks are gated whenever the aux rail is off
    p_clk_off_rails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_rail_en |-> (clk_gate_en == '0));

    // R7: aux rail rises only after memory was already on
    p_mem_before_aux_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_rail_en) |-> $past(mem_rail_en));

    // R8: wake status holds without a write-one clear
    p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts && !(wr_en && wr_addr == 2'd1 && wr_data[0])) |=> wake_sts);

endmodule

bind pwr_seq_top pwr_seq_chk #(
    .DATA_W(DATA_W),
    .NCLK  (NCLK)
) u_chk (
    .clk        (clk_32k),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mem_rail_en(mem_rail_en),
    .aux_rail_en(aux_rail_en),
    .clk_gate_en(clk_gate_en),
    .dev_sleep  (dev_sleep),
    .io_isolate (io_isolate),
    .sr_req     (sr_req),
    .state_code (state_code),
    .wake_sts   (wake_sts)
);

// File: tb/pwr_seq_top_test.sv
// Directed bench for pwr_seq_top: one task per scenario, each checking its own results.
module pwr_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int NCLK   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_joint_pwrup = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wake_evt = 1'b0;
    logic              sr_ack = 1'b0;
    logic              mem_rail_en, aux_rail_en, io_isolate, sr_req, wake_sts;
    logic [NCLK-1:0]   clk_gate_en;
    logic [1:0]        dev_sleep;
    logic [2:0]        state_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    pwr_seq_top #(.DATA_W(DATA_W), .NCLK(NCLK), .DLY_W(8), .DLY_RST(4)) uut (
        .clk_32k(clk), .rst_n(rst_n), .cfg_joint_pwrup(cfg_joint_pwrup),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wake_evt(wake_evt), .sr_ack(sr_ack),
        .mem_rail_en(mem_rail_en), .aux_rail_en(aux_rail_en),
        .clk_gate_en(clk_gate_en), .dev_sleep(dev_sleep), .io_isolate(io_isolate),
        .sr_req(sr_req), .state_code(state_code), .wake_sts(wake_sts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic joint);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_joint_pwrup = joint;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    // Count cycles until the aux rail rises, then until all clocks are on.
    task automatic measure_wakeup(input string req, input int exp_steps);
        int c1 = 0;
        int c2 = 0;
        check({req, " mem rail first"}, mem_rail_en, 1);
        check({req, " aux still off"}, aux_rail_en, 0);
        check({req, " code during wake"}, state_code, 0);
        while (!aux_rail_en && c1 < 300) begin @(negedge clk); c1++; end
        check({req, " mem-to-aux cycles"}, c1, exp_steps);
        check({req, " clocks still gated"}, clk_gate_en, 0);
        while (clk_gate_en != 4'hF && c2 < 300) begin @(negedge clk); c2++; end
        check({req, " aux-to-clock cycles"}, c2, exp_steps);
        check({req, " sr_req released"}, sr_req, 0);
        check({req, " back in S0"}, state_code, 0);
    endtask

    task automatic t_reset_joint();
        do_reset(1'b1);
        check("R1 joint mem", mem_rail_en, 1);
        check("R1 joint aux", aux_rail_en, 1);
        check("R1 joint clocks", clk_gate_en, 4'hF);
        check("R1 joint dev_sleep", dev_sleep, 0);
        check("R1 joint isolate", io_isolate, 0);
        check("R1 joint code", state_code, 0);
        check("R1 joint wake_sts", wake_sts, 0);
    endtask

    task automatic t_bad_codes();
        for (int i = 0; i < 8; i++) begin
            if (i == 0 || i == 2 || i == 6 || i == 7) begin
                reg_write(2'd0, DATA_W'(i));
                check("R2 ignored code state", state_code, 0);
                check("R2 ignored code clocks", clk_gate_en, 4'hF);
            end
        end
    endtask

    task automatic t_s1();
        reg_write(2'd2, 8'h05);
        reg_write(2'd0, 8'd1);
        check("R3 S1 code", state_code, 1);
        check("R3 S1 mem", mem_rail_en, 1);
        check("R3 S1 aux", aux_rail_en, 1);
        check("R10 R3 S1 keep mask", clk_gate_en, 4'h5);
        check("R3 S1 dev_sleep", dev_sleep, 3);
        check("R3 S1 isolate", io_isolate, 1);
        repeat (5) @(negedge clk);
        check("R3 S1 held without wake", state_code, 1);
        pulse_wake();
        check("R4 S1 wake code", state_code, 0);
        check("R4 S1 wake clocks", clk_gate_en, 4'hF);
        check("R4 S1 wake dev_sleep", dev_sleep, 0);
        check("R4 S1 wake isolate", io_isolate, 0);
        check("R8 wake_sts set", wake_sts, 1);
    endtask

    task automatic t_wake_sts();
        reg_write(2'd1, 8'h00);
        check("R8 write 0 keeps status", wake_sts, 1);
        reg_write(2'd1, 8'h01);
        check("R8 write 1 clears", wake_sts, 0);
    endtask

    task automatic t_wake_in_s0();
        pulse_wake();
        check("R9 S0 wake state", state_code, 0);
        check("R9 S0 wake clocks", clk_gate_en, 4'hF);
        check("R9 S0 wake status", wake_sts, 0);
    endtask

    task automatic t_s3();
        reg_write(2'd3, 8'd2);
        reg_write(2'd0, 8'd3);
        check("R5 entry code", state_code, 3);
        check("R5 entry sr_req", sr_req, 1);
        check("R5 entry aux held", aux_rail_en, 1);
        check("R5 entry mem", mem_rail_en, 1);
        check("R5 entry clocks gated", clk_gate_en, 0);
        repeat (4) @(negedge clk);
        check("R5 aux held before ack", aux_rail_en, 1);
        pulse_wake();
        check("R9 wake during entry state", state_code, 3);
        check("R9 wake during entry aux", aux_rail_en, 1);
        check("R9 wake during entry status", wake_sts, 0);
        sr_ack = 1'b1;
        @(negedge clk);
        sr_ack = 1'b0;
        check("R5 S3 aux off", aux_rail_en, 0);
        check("R5 S3 mem on", mem_rail_en, 1);
        check("R5 S3 code", state_code, 3);
        reg_write(2'd0, 8'd1);
        check("R2 request outside S0 ignored", state_code, 3);
        pulse_wake();
        check("R8 wake from S3 status", wake_sts, 1);
        measure_wakeup("R7 S3 step2", 3);
    endtask

    task automatic t_s4();
        reg_write(2'd3, 8'd3);
        reg_write(2'd0, 8'd4);
        check("R6 S4 code", state_code, 4);
        check("R6 S4 mem", mem_rail_en, 0);
        check("R6 S4 aux", aux_rail_en, 0);
        check("R6 S4 clocks", clk_gate_en, 0);
        pulse_wake();
        measure_wakeup("R7 S4 step3", 4);
    endtask

    task automatic t_s5();
        reg_write(2'd3, 8'd0);
        reg_write(2'd0, 8'd5);
        check("R6 S5 code", state_code, 5);
        check("R6 S5 mem", mem_rail_en, 0);
        check("R6 S5 aux", aux_rail_en, 0);
        check("R6 S5 dev_sleep", dev_sleep, 3);
        pulse_wake();
        measure_wakeup("R7 S5 step0", 1);
    endtask

    task automatic t_reset_split();
        do_reset(1'b0);
        check("R1 split code", state_code, 5);
        check("R1 split mem", mem_rail_en, 0);
        check("R1 split aux", aux_rail_en, 0);
        check("R1 split clocks", clk_gate_en, 0);
        pulse_wake();
        measure_wakeup("R10 reset step default", 5);
    endtask

    initial begin
        t_reset_joint();
        t_bad_codes();
        t_s1();
        t_wake_sts();
        t_wake_in_s0();
        t_s3();
        t_s4();
        t_s5();
        t_reset_split();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule